// File: doc/BRIEF.md
# AXI4-Lite to Register Bridge with Clock Crossing

This block is an AXI4-Lite slave that runs on a CPU clock. It turns each bus access into one transfer on a simple 32-bit register port that runs on a separate user clock. The write address and the write data are captured on their own channels, joined into one transfer, and presented to the register side as a single-cycle write strobe. The strobe carries a word address, the data and the byte enables. A read address becomes a single-cycle read request. The register-side slave answers it with a read-valid pulse and the data after any number of cycles, and the bridge then returns that data on the read data channel.

Both clock domains see only held values. A request flag and an acknowledge flag carry the transfer between the domains: each is a toggle that passes through a synchronizer. Only one transfer is in flight at a time, so the register side shares a single address bus between reads and writes. When a write and a read become pending together, the write goes first. Bursts, error responses and address decoding are outside this block.

Top module: `axil_reg_bridge`

## Requirements
- R1: Once both the write address and the write data handshakes have completed, `reg_wr_en` is high for exactly one user clock. In that cycle `reg_addr` equals the byte address shifted right by two, `reg_wr_data` equals the write data, and `reg_wr_be` equals the write strobes. Bit n of `reg_wr_be` marks byte n (bits 8n+7..8n) as valid.
- R2: `bvalid` rises only after the write strobe has been issued on the register side. It then stays high until `bready` is seen, and `bresp` is 2'b00 (OKAY).
- R3: A read issues `reg_rd_req` for exactly one user clock with `reg_addr` equal to the read byte address shifted right by two. `reg_addr` stays unchanged until `reg_rd_valid` arrives.
- R4: `rdata` equals the `reg_rd_data` value present with `reg_rd_valid`, and `rresp` is 2'b00. Once `rvalid` is high, it and `rdata` hold steady until `rready` is seen.
- R5: When a complete write and a read are pending together, the write strobe is issued before the read request, so the read returns the newly written value.
- R6: `reg_wr_en` and `reg_rd_req` are never high together, and `bvalid` and `rvalid` are never high together.
- R7: The write address and write data channels complete independently and in either order. After its handshake, each ready signal stays low until the write response handshake. `arready` likewise stays low until the read data handshake.
- R8: While reset is applied and after it is released, `awready`, `wready` and `arready` are high, and `bvalid`, `rvalid`, `reg_wr_en` and `reg_rd_req` are low.
- R9: Any read latency on the register side is accepted. A `reg_rd_valid` pulse that arrives while no read is pending has no effect: no `rvalid` appears, and later reads return correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Bus-side clock |
| cpu_rst | input | 1 | Synchronous active-high reset, bus side |
| usr_clk | input | 1 | Register-side clock |
| usr_rst | input | 1 | Synchronous active-high reset, register side |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| reg_addr | output | ADDR_W-2 | Shared word address |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wr_data | output | DATA_W | Write data |
| reg_wr_be | output | DATA_W/8 | Write byte enables |
| reg_rd_req | output | 1 | Single-cycle read request |
| reg_rd_valid | input | 1 | Read data valid from the register slave |
| reg_rd_data | input | DATA_W | Read data from the register slave |

## Verification
The bench sweeps every word address against every one of the sixteen byte-enable patterns. The address and data channels are presented together, address first and data first. Each write is read back through a model memory, which shows whether strobe bits reach the right bytes and whether channel order matters. Read latencies from zero to several user cycles, with back-pressure held on `bready` and `rready`, separate a bridge that waits on the valid handshake from one that assumes a fixed delay. Two further patterns target priority and misuse. A simultaneous write and read to one address tells write-first ordering apart from read-first. Stray read-valid pulses with no request pending show whether spurious responses leak onto the bus.

// File: rtl/axil_bridge_pkg.sv
package axil_bridge_pkg;
  typedef enum logic [2:0] {
    C_IDLE, C_WR_WAIT, C_RD_WAIT, C_B_RESP, C_R_RESP
  } cpu_state_t;

  typedef enum logic [1:0] {
    U_IDLE, U_WR_STB, U_RD_WAIT
  } usr_state_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/xdom_flag_sync.sv
module xdom_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_cpu_port.sv
module bridge_cpu_port
  import axil_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              xfer_is_wr,
  output logic [DATA_W-1:0] xfer_data,
  output logic [STRB_W-1:0] xfer_strb,
  output logic              req_tgl,
  input  logic              ack_in,
  input  logic [DATA_W-1:0] rd_hold
);
  cpu_state_t        state;
  logic              aw_full, w_full, ar_full;
  logic [ADDR_W-1:0] aw_addr_q, ar_addr_q;
  logic [DATA_W-1:0] w_data_q;
  logic [STRB_W-1:0] w_strb_q;
  logic              ack_seen;
  logic              ack_edge;

  assign awready  = ~aw_full;
  assign wready   = ~w_full;
  assign arready  = ~ar_full;
  assign bresp    = RESP_OKAY;
  assign rresp    = RESP_OKAY;
  assign ack_edge = ack_in ^ ack_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= C_IDLE;
      aw_full    <= 1'b0;
      w_full     <= 1'b0;
      ar_full    <= 1'b0;
      aw_addr_q  <= '0;
      ar_addr_q  <= '0;
      w_data_q   <= '0;
      w_strb_q   <= '0;
      xfer_addr  <= '0;
      xfer_is_wr <= 1'b0;
      xfer_data  <= '0;
      xfer_strb  <= '0;
      req_tgl    <= 1'b0;
      ack_seen   <= 1'b0;
      bvalid     <= 1'b0;
      rvalid     <= 1'b0;
      rdata      <= '0;
    end else begin
      if (awvalid && !aw_full) begin
        aw_full   <= 1'b1;
        aw_addr_q <= awaddr;
      end
      if (wvalid && !w_full) begin
        w_full   <= 1'b1;
        w_data_q <= wdata;
        w_strb_q <= wstrb;
      end
      if (arvalid && !ar_full) begin
        ar_full   <= 1'b1;
        ar_addr_q <= araddr;
      end

      case (state)
        C_IDLE: begin
          if (aw_full && w_full) begin
            xfer_addr  <= aw_addr_q;
            xfer_data  <= w_data_q;
            xfer_strb  <= w_strb_q;
            xfer_is_wr <= 1'b1;
            req_tgl    <= ~req_tgl;
            state      <= C_WR_WAIT;
          end else if (ar_full) begin
            xfer_addr  <= ar_addr_q;
            xfer_is_wr <= 1'b0;
            req_tgl    <= ~req_tgl;
            state      <= C_RD_WAIT;
          end
        end
        C_WR_WAIT: begin
          if (ack_edge) begin
            ack_seen <= ack_in;
            bvalid   <= 1'b1;
            state    <= C_B_RESP;
          end
        end
        C_RD_WAIT: begin
          if (ack_edge) begin
            ack_seen <= ack_in;
            rdata    <= rd_hold;
            rvalid   <= 1'b1;
            state    <= C_R_RESP;
          end
        end
        C_B_RESP: begin
          if (bready) begin
            bvalid  <= 1'b0;
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            state   <= C_IDLE;
          end
        end
        C_R_RESP: begin
          if (rready) begin
            rvalid  <= 1'b0;
            ar_full <= 1'b0;
            state   <= C_IDLE;
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  // R2: response held until accepted
  a_r2_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid);

  // R4: read data held until accepted
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));

  // R6: only one response channel active
  a_r6_one_resp: assert property (@(posedge clk) disable iff (rst)
    !(bvalid && rvalid));

  // R7: write address blocked while a write response is outstanding
  a_r7_aw_blocked: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> !awready);
endmodule

// File: rtl/bridge_usr_port.sv
module bridge_usr_port
  import axil_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8,
  parameter int REG_AW = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_in,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_is_wr,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic [STRB_W-1:0] xfer_strb,
  output logic              ack_tgl,
  output logic [DATA_W-1:0] rd_hold,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [STRB_W-1:0] reg_wr_be,
  output logic              reg_rd_req,
  input  logic              reg_rd_valid,
  input  logic [DATA_W-1:0] reg_rd_data
);
  usr_state_t state;
  logic       req_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= U_IDLE;
      req_seen    <= 1'b0;
      ack_tgl     <= 1'b0;
      rd_hold     <= '0;
      reg_addr    <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      reg_wr_be   <= '0;
      reg_rd_req  <= 1'b0;
    end else begin
      reg_wr_en  <= 1'b0;
      reg_rd_req <= 1'b0;
      case (state)
        U_IDLE: begin
          if (req_in != req_seen) begin
            req_seen <= req_in;
            reg_addr <= xfer_addr[ADDR_W-1:2];
            if (xfer_is_wr) begin
              reg_wr_en   <= 1'b1;
              reg_wr_data <= xfer_data;
              reg_wr_be   <= xfer_strb;
              state       <= U_WR_STB;
            end else begin
              reg_rd_req <= 1'b1;
              state      <= U_RD_WAIT;
            end
          end
        end
        U_WR_STB: begin
          ack_tgl <= ~ack_tgl;
          state   <= U_IDLE;
        end
        U_RD_WAIT: begin
          if (reg_rd_valid) begin
            rd_hold <= reg_rd_data;
            ack_tgl <= ~ack_tgl;
            state   <= U_IDLE;
          end
        end
        default: state <= U_IDLE;
      endcase
    end
  end

  // R1: write strobe lasts one cycle
  a_r1_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  // R3: read request lasts one cycle
  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_rd_req |=> !reg_rd_req);

  // R3: address held while the read is outstanding
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (state == U_RD_WAIT && !reg_rd_valid) |=> $stable(reg_addr));

  // R6: write and read never share a cycle
  a_r6_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_rd_req));
endmodule

// File: rtl/axil_reg_bridge.sv
module axil_reg_bridge #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  cpu_clk,
  input  logic                  cpu_rst,
  input  logic                  usr_clk,
  input  logic                  usr_rst,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [DATA_W-1:0]     s_wdata,
  input  logic [DATA_W/8-1:0]   s_wstrb,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [ADDR_W-1:0]     s_araddr,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [DATA_W-1:0]     s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic [ADDR_W-3:0]     reg_addr,
  output logic                  reg_wr_en,
  output logic [DATA_W-1:0]     reg_wr_data,
  output logic [DATA_W/8-1:0]   reg_wr_be,
  output logic                  reg_rd_req,
  input  logic                  reg_rd_valid,
  input  logic [DATA_W-1:0]     reg_rd_data
);
  localparam int STRB_W = DATA_W / 8;
  localparam int REG_AW = ADDR_W - 2;

  logic [ADDR_W-1:0] xfer_addr;
  logic              xfer_is_wr;
  logic [DATA_W-1:0] xfer_data;
  logic [STRB_W-1:0] xfer_strb;
  logic              req_tgl, req_sync;
  logic              ack_tgl, ack_sync;
  logic [DATA_W-1:0] rd_hold;

  bridge_cpu_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)
  ) u_cpu (
    .clk(cpu_clk), .rst(cpu_rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .xfer_addr(xfer_addr), .xfer_is_wr(xfer_is_wr),
    .xfer_data(xfer_data), .xfer_strb(xfer_strb),
    .req_tgl(req_tgl), .ack_in(ack_sync), .rd_hold(rd_hold)
  );

  xdom_flag_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(usr_clk), .rst(usr_rst), .d(req_tgl), .q(req_sync)
  );

  xdom_flag_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(cpu_clk), .rst(cpu_rst), .d(ack_tgl), .q(ack_sync)
  );

  bridge_usr_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W), .REG_AW(REG_AW)
  ) u_usr (
    .clk(usr_clk), .rst(usr_rst),
    .req_in(req_sync),
    .xfer_addr(xfer_addr), .xfer_is_wr(xfer_is_wr),
    .xfer_data(xfer_data), .xfer_strb(xfer_strb),
    .ack_tgl(ack_tgl), .rd_hold(rd_hold),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be),
    .reg_rd_req(reg_rd_req), .reg_rd_valid(reg_rd_valid),
    .reg_rd_data(reg_rd_data)
  );
endmodule

// File: tb/sim_axil_reg_bridge.sv
`timescale 1ns/1ps
module sim_axil_reg_bridge;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NW = 1 << (AW - 2);

  logic cclk = 1'b0, uclk = 1'b0;
  logic crst = 1'b1, urst = 1'b1;
  always #10 cclk = ~cclk;
  always #7  uclk = ~uclk;

  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic bready = 1'b0, rready = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, arready, bvalid, rvalid;
  logic [1:0] bresp, rresp;
  logic [DW-1:0] rdata;
  logic [AW-3:0] reg_addr;
  logic reg_wr_en, reg_rd_req;
  logic [DW-1:0] reg_wr_data;
  logic [3:0] reg_wr_be;
  logic reg_rd_valid = 1'b0;
  logic [DW-1:0] reg_rd_data = '0;

  axil_reg_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .cpu_clk(cclk), .cpu_rst(crst), .usr_clk(uclk), .usr_rst(urst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
    .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NW];
  logic [DW-1:0] smem  [NW];
  int wr_cnt = 0, rd_cnt = 0, first_ev = 0;
  int rd_lat = 0, junk_cnt = 0;
  logic [AW-3:0] exp_addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic [3:0]    exp_be = '0;
  bit pend = 1'b0;
  int pcnt = 0;
  logic [AW-3:0] paddr = '0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // register slave model on the user clock, sampled away from the active edge
  always @(negedge uclk) begin
    if (!urst) begin
      reg_rd_valid = 1'b0;
      if (reg_wr_en && reg_rd_req) chk(0, "R6 strobe overlap", 1, 0);
      if (reg_wr_en) begin
        wr_cnt++;
        if (first_ev == 0) first_ev = 1;
        chk(reg_addr == exp_addr, "R1 wr addr", DW'(reg_addr), DW'(exp_addr));
        chk(reg_wr_data == exp_data, "R1 wr data", reg_wr_data, exp_data);
        chk(reg_wr_be == exp_be, "R1 wr be", DW'(reg_wr_be), DW'(exp_be));
        for (int k = 0; k < 4; k++)
          if (reg_wr_be[k]) smem[reg_addr][8*k +: 8] = reg_wr_data[8*k +: 8];
      end
      if (reg_rd_req) begin
        rd_cnt++;
        if (first_ev == 0) first_ev = 2;
        pend = 1'b1; pcnt = rd_lat; paddr = reg_addr;
      end else if (pend) begin
        if (reg_addr != paddr) chk(0, "R3 addr hold", DW'(reg_addr), DW'(paddr));
        if (pcnt == 0) begin
          reg_rd_valid = 1'b1;
          reg_rd_data  = smem[paddr];
          pend = 1'b0;
        end else pcnt--;
      end
      if (junk_cnt > 0) begin
        reg_rd_valid = 1'b1;
        reg_rd_data  = 32'hDEAD_BEEF;
        junk_cnt--;
      end
    end
  end

  task automatic send_aw(input logic [AW-1:0] a);
    bit r;
    awaddr = a; awvalid = 1'b1;
    do begin r = awready; @(negedge cclk); end while (!r);
    awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [DW-1:0] d, input logic [3:0] s);
    bit r;
    wdata = d; wstrb = s; wvalid = 1'b1;
    do begin r = wready; @(negedge cclk); end while (!r);
    wvalid = 1'b0;
  endtask

  task automatic send_ar(input logic [AW-1:0] a);
    bit r;
    araddr = a; arvalid = 1'b1;
    do begin r = arready; @(negedge cclk); end while (!r);
    arvalid = 1'b0;
  endtask

  task automatic model_wr(input int i, input logic [DW-1:0] d, input logic [3:0] s);
    for (int k = 0; k < 4; k++) if (s[k]) model[i][8*k +: 8] = d[8*k +: 8];
  endtask

  task automatic finish_b(input int w0, input int hold);
    while (!bvalid) @(negedge cclk);
    chk(wr_cnt == w0 + 1, "R2 b after strobe", DW'(wr_cnt), DW'(w0 + 1));
    chk(bresp == 2'b00, "R2 bresp", DW'(bresp), 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge cclk);
      chk(bvalid, "R2 bvalid held", DW'(bvalid), 1);
    end
    bready = 1'b1; @(negedge cclk); bready = 1'b0;
    chk(!bvalid, "R2 bvalid drop", DW'(bvalid), 0);
  endtask

  task automatic axi_write(input int i, input logic [DW-1:0] d, input logic [3:0] s,
                           input int order, input int hold);
    int w0;
    w0 = wr_cnt;
    exp_addr = i[AW-3:0]; exp_data = d; exp_be = s;
    fork
      begin if (order == 2) repeat (3) @(negedge cclk); send_aw(AW'(i * 4)); end
      begin if (order == 1) repeat (3) @(negedge cclk); send_w(d, s); end
    join
    finish_b(w0, hold);
    model_wr(i, d, s);
  endtask

  task automatic finish_r(input int i, input int hold, input string tag);
    logic [DW-1:0] d;
    while (!rvalid) @(negedge cclk);
    d = rdata;
    chk(d == model[i], tag, d, model[i]);
    chk(rresp == 2'b00, "R4 rresp", DW'(rresp), 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge cclk);
      chk(rvalid && rdata == d, "R4 rdata held", rdata, d);
    end
    rready = 1'b1; @(negedge cclk); rready = 1'b0;
  endtask

  task automatic axi_read(input int i, input int lat, input int hold);
    int r0;
    r0 = rd_cnt;
    rd_lat = lat;
    send_ar(AW'(i * 4));
    finish_r(i, hold, "R4 read data");
    chk(rd_cnt == r0 + 1, "R3 one request", DW'(rd_cnt), DW'(r0 + 1));
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin model[i] = '0; smem[i] = '0; end
    repeat (5) @(negedge cclk);
    crst = 1'b0;
    @(negedge uclk); urst = 1'b0;
    @(negedge cclk);
    // R8 reset state
    chk(awready && wready && arready, "R8 readies", {awready, wready, arready}, 3'b111);
    chk(!bvalid && !rvalid, "R8 valids", {bvalid, rvalid}, 0);
    chk(!reg_wr_en && !reg_rd_req, "R8 strobes", {reg_wr_en, reg_rd_req}, 0);

    // R1 R7 R9 sweep of every word and byte-enable pattern, all channel orders
    for (int a = 0; a < NW; a++) begin
      for (int s = 0; s < 16; s++) begin
        logic [DW-1:0] d;
        d = (32'(a) << 24) | (32'(s) << 16) | 32'((a * 37 + s * 11) & 16'hFFFF);
        axi_write(a, d, 4'(s), (a + s) % 3, s % 3);
        axi_read(a, (a + s) % 6, a % 2);
      end
    end

    // R7 write channels held off while the response is pending
    begin
      int w0;
      w0 = wr_cnt;
      exp_addr = 4'd3; exp_data = 32'h1234_5678; exp_be = 4'hF;
      fork send_aw(AW'(12)); send_w(32'h1234_5678, 4'hF); join
      while (!bvalid) @(negedge cclk);
      awaddr = AW'(20); awvalid = 1'b1;
      repeat (3) begin
        @(negedge cclk);
        chk(!awready && !wready, "R7 ready low", {awready, wready}, 0);
      end
      chk(wr_cnt == w0 + 1, "R7 no second strobe", DW'(wr_cnt), DW'(w0 + 1));
      bready = 1'b1; @(negedge cclk); bready = 1'b0;
      model_wr(3, 32'h1234_5678, 4'hF);
      chk(awready, "R7 ready back", DW'(awready), 1);
      @(negedge cclk); awvalid = 1'b0;
      w0 = wr_cnt;
      exp_addr = 4'd5; exp_data = 32'hCAFE_0001; exp_be = 4'h5;
      send_w(32'hCAFE_0001, 4'h5);
      finish_b(w0, 0);
      model_wr(5, 32'hCAFE_0001, 4'h5);
      axi_read(5, 1, 0);
    end

    // R5 write wins over a simultaneous read of the same word
    begin
      int w0;
      w0 = wr_cnt;
      first_ev = 0; rd_lat = 2;
      exp_addr = 4'd9; exp_data = 32'h0BAD_F00D; exp_be = 4'hF;
      fork send_aw(AW'(36)); send_w(32'h0BAD_F00D, 4'hF); send_ar(AW'(36)); join
      finish_b(w0, 1);
      model_wr(9, 32'h0BAD_F00D, 4'hF);
      finish_r(9, 0, "R5 read sees write");
      chk(first_ev == 1, "R5 write first", DW'(first_ev), 1);
    end

    // R9 stray read-valid with no request pending
    junk_cnt = 3;
    repeat (10) begin
      @(negedge cclk);
      chk(!rvalid, "R9 no stray rvalid", DW'(rvalid), 0);
    end
    axi_read(9, 0, 0);
    axi_read(3, 7, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge cclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule